// File: doc/BRIEF.md
# Vector display command completion timer

This block decides when a point-plotting display controller is ready for its next command. The controller sits on a minicomputer I/O bus. A decoder outside this block turns bus instructions into single-cycle strobes. There are four of them: load X, load Y, intensify and load status. Each strobe drops the ready flag (DONE) and starts a one-shot timer for that operation. The timer stands for the time the analog hardware needs to finish the operation. When the last running timer expires, DONE is raised again.

All timer lengths are given in nanoseconds and turned into clock cycles from a clock-frequency parameter. The movement delay depends on two things: a long/short length-select input, and the colour currently selected through the status word. A status load that changes the colour adds a longer settling delay before DONE can return. A separate path watches the erase-interval input and emits a fixed-length pulse when an erase ends.

Top module: `vecdisp_done_timer`

## Requirements
- R1: While and after `rst`, `done`, every bit of `busy` and `erase_end` are low. The current colour is 0. DONE stays low until the first completion edge after reset.
- R2: Any of `cmd_ld_x`, `cmd_ld_y`, `cmd_intens` or `cmd_ld_stat` sampled high at a clock edge makes `done` low after that edge.
- R3: `done` goes high one clock after the cycle in which every `busy` bit first reads low following a period with at least one bit high. It then holds until it is cleared. `done` is never high while any `busy` bit is high.
- R4: With colour 0, a load X or load Y raises `busy[0]` for exactly ceil(2600 ns × f) cycles when `len_long`=0, and for exactly ceil(8800 ns × f) cycles when `len_long`=1. Here f is the clock frequency.
- R5: With colour 1, the movement delay uses the second timing set instead: 3400 ns when short and 11000 ns when long, with the same rounding. The colour is the `stat_colour` value captured by the most recent status load.
- R6: An intensify strobe raises `busy[1]` for exactly ceil(6000 ns × f) cycles.
- R7: A status load raises `busy[2]` for exactly ceil(500 ns × f) cycles. Every timer length is rounded up to whole cycles, with a minimum of one.
- R8: A status load whose `stat_colour` differs from the current colour also raises `busy[3]` for exactly ceil(20000 ns × f) cycles. A status load with an unchanged colour leaves `busy[3]` low.
- R9: A strobe that arrives while its timer is still running restarts that timer at its full length.
- R10: `clr_done` sampled high makes `done` low after that edge. `done` stays low until a new completion edge occurs.
- R11: A high-to-low transition of `erase_ival` raises `erase_end` for exactly ceil(1000 ns × f) cycles, starting the edge after the low level is first sampled. It has no effect on `done` or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_ld_x | input | 1 | Load-X strobe, one cycle |
| cmd_ld_y | input | 1 | Load-Y strobe, one cycle |
| cmd_intens | input | 1 | Intensify strobe, one cycle |
| cmd_ld_stat | input | 1 | Load-status strobe, one cycle |
| stat_colour | input | 1 | Colour bit of the status word being loaded (0 = first set, 1 = second set) |
| len_long | input | 1 | Movement length select: 0 short, 1 long |
| erase_ival | input | 1 | High during an erase interval |
| clr_done | input | 1 | Clears DONE |
| done | output | 1 | Ready flag |
| busy | output | 4 | Timer busy bits: [0] movement, [1] intensify, [2] status load, [3] colour settle |
| erase_end | output | 1 | End-of-erase pulse |

## Verification
The bench builds the block with `CLK_KHZ`=3000 and keeps the default nanosecond lengths. Every timer then lasts 2 to 60 cycles. This puts each full duration, each expiry edge and each restart within reach thousands of times in a short run. Most of the products are not whole numbers (2600 ns gives 7.8 cycles, and 500 ns gives 1.5 cycles), so the round-up rule is checked at its exact boundary cycle. Random strobes that overlap or coincide on the same edge exercise the case where DONE waits for the last of several timers.

// File: rtl/vdt_pkg.sv
`timescale 1ns/1ps
package vdt_pkg;

  localparam int unsigned NUM_TMR    = 4;
  localparam int unsigned TMR_MOVE   = 0;
  localparam int unsigned TMR_INTENS = 1;
  localparam int unsigned TMR_STAT   = 2;
  localparam int unsigned TMR_SETTLE = 3;

  typedef struct packed {
    logic ld_x;
    logic ld_y;
    logic intens;
    logic ld_stat;
  } cmd_t;

  // ceil(ns * kHz / 1e6) cycles, never below one
  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned khz);
    longint unsigned c;
    c = (ns * khz + 64'd999999) / 64'd1000000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vdt_oneshot.sv
`timescale 1ns/1ps
// Retriggerable one-shot: busy for exactly len cycles after the start edge.
module vdt_oneshot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         busy
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= len - 1'b1;
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/vdt_colour_track.sv
`timescale 1ns/1ps
// Holds the current colour and flags a status load that changes it.
module vdt_colour_track (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic new_colour,
  output logic colour,
  output logic change
);

  assign change = ld && (new_colour != colour);

  always_ff @(posedge clk) begin
    if (rst)     colour <= 1'b0;
    else if (ld) colour <= new_colour;
  end

endmodule

// File: rtl/vdt_done_flag.sv
`timescale 1ns/1ps
// Sets the ready flag on the rising edge of the all-idle condition.
module vdt_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic all_idle,
  input  logic clear,
  output logic done
);

  logic idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b1;
      done   <= 1'b0;
    end else begin
      idle_q <= all_idle;
      if (clear)                   done <= 1'b0;
      else if (all_idle && !idle_q) done <= 1'b1;
    end
  end

endmodule

// File: rtl/vecdisp_done_timer.sv
`timescale 1ns/1ps
module vecdisp_done_timer
  import vdt_pkg::*;
#(
  parameter int unsigned CLK_KHZ        = 200000,
  parameter int unsigned MOVE_A_SHORT_NS = 2600,
  parameter int unsigned MOVE_A_LONG_NS  = 8800,
  parameter int unsigned MOVE_B_SHORT_NS = 3400,
  parameter int unsigned MOVE_B_LONG_NS  = 11000,
  parameter int unsigned INTENS_NS       = 6000,
  parameter int unsigned STAT_NS         = 500,
  parameter int unsigned SETTLE_NS       = 20000,
  parameter int unsigned ERASE_NS        = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_ld_x,
  input  logic               cmd_ld_y,
  input  logic               cmd_intens,
  input  logic               cmd_ld_stat,
  input  logic               stat_colour,
  input  logic               len_long,
  input  logic               erase_ival,
  input  logic               clr_done,
  output logic               done,
  output logic [NUM_TMR-1:0] busy,
  output logic               erase_end
);

  localparam int unsigned L_AS  = ns_to_cyc(MOVE_A_SHORT_NS, CLK_KHZ);
  localparam int unsigned L_AL  = ns_to_cyc(MOVE_A_LONG_NS,  CLK_KHZ);
  localparam int unsigned L_BS  = ns_to_cyc(MOVE_B_SHORT_NS, CLK_KHZ);
  localparam int unsigned L_BL  = ns_to_cyc(MOVE_B_LONG_NS,  CLK_KHZ);
  localparam int unsigned L_INT = ns_to_cyc(INTENS_NS,       CLK_KHZ);
  localparam int unsigned L_STA = ns_to_cyc(STAT_NS,         CLK_KHZ);
  localparam int unsigned L_SET = ns_to_cyc(SETTLE_NS,       CLK_KHZ);
  localparam int unsigned L_ERA = ns_to_cyc(ERASE_NS,        CLK_KHZ);
  localparam int unsigned L_MAX = max2(max2(max2(L_AS, L_AL), max2(L_BS, L_BL)),
                                       max2(max2(L_INT, L_STA), max2(L_SET, L_ERA)));
  localparam int unsigned CW    = $clog2(L_MAX + 1);

  cmd_t cmd;
  assign cmd = '{ld_x: cmd_ld_x, ld_y: cmd_ld_y, intens: cmd_intens, ld_stat: cmd_ld_stat};

  logic any_cmd;
  assign any_cmd = cmd.ld_x | cmd.ld_y | cmd.intens | cmd.ld_stat;

  // colour state
  logic colour, colour_change;
  vdt_colour_track u_colour (
    .clk        (clk),
    .rst        (rst),
    .ld         (cmd.ld_stat),
    .new_colour (stat_colour),
    .colour     (colour),
    .change     (colour_change)
  );

  // movement length chosen by colour and length switch
  logic [CW-1:0] move_len;
  always_comb begin
    unique case ({colour, len_long})
      2'b00:   move_len = CW'(L_AS);
      2'b01:   move_len = CW'(L_AL);
      2'b10:   move_len = CW'(L_BS);
      default: move_len = CW'(L_BL);
    endcase
  end

  logic [NUM_TMR-1:0] tmr_start;
  logic [CW-1:0]      tmr_len [NUM_TMR];
  logic [NUM_TMR-1:0] tmr_busy;

  always_comb begin
    tmr_start[TMR_MOVE]   = cmd.ld_x | cmd.ld_y;
    tmr_start[TMR_INTENS] = cmd.intens;
    tmr_start[TMR_STAT]   = cmd.ld_stat;
    tmr_start[TMR_SETTLE] = colour_change;
    tmr_len[TMR_MOVE]     = move_len;
    tmr_len[TMR_INTENS]   = CW'(L_INT);
    tmr_len[TMR_STAT]     = CW'(L_STA);
    tmr_len[TMR_SETTLE]   = CW'(L_SET);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_TMR; g++) begin : g_tmr
      vdt_oneshot #(.W(CW)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start[g]),
        .len   (tmr_len[g]),
        .busy  (tmr_busy[g])
      );
    end
  endgenerate

  assign busy = tmr_busy;

  vdt_done_flag u_done (
    .clk      (clk),
    .rst      (rst),
    .all_idle (tmr_busy == '0),
    .clear    (any_cmd | clr_done),
    .done     (done)
  );

  // end-of-erase pulse, outside the completion AND
  logic erase_q;
  always_ff @(posedge clk) begin
    if (rst) erase_q <= 1'b0;
    else     erase_q <= erase_ival;
  end

  vdt_oneshot #(.W(CW)) u_erase (
    .clk   (clk),
    .rst   (rst),
    .start (erase_q & ~erase_ival),
    .len   (CW'(L_ERA)),
    .busy  (erase_end)
  );

endmodule

// File: rtl/vdt_checker.sv
`timescale 1ns/1ps
module vdt_checker
  import vdt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cmd_ld_x,
  input logic               cmd_ld_y,
  input logic               cmd_intens,
  input logic               cmd_ld_stat,
  input logic               erase_ival,
  input logic               clr_done,
  input logic               done,
  input logic [NUM_TMR-1:0] busy,
  input logic               erase_end
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && busy == '0 && !erase_end));

  assert_cmd_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_ld_x || cmd_ld_y || cmd_intens || cmd_ld_stat) |=> !done);

  assert_done_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy == '0));

  assert_move_starts_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_ld_x || cmd_ld_y) |=> busy[TMR_MOVE]);

  assert_intens_starts_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_intens |=> busy[TMR_INTENS]);

  assert_stat_starts_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_ld_stat |=> busy[TMR_STAT]);

  assert_settle_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy[TMR_SETTLE]) |-> $past(cmd_ld_stat));

  assert_clear_flag_R10: assert property (@(posedge clk) disable iff (rst)
    clr_done |=> !done);

  assert_erase_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(erase_ival) && !erase_ival) |=> erase_end);

endmodule

bind vecdisp_done_timer vdt_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_ld_x    (cmd_ld_x),
  .cmd_ld_y    (cmd_ld_y),
  .cmd_intens  (cmd_intens),
  .cmd_ld_stat (cmd_ld_stat),
  .erase_ival  (erase_ival),
  .clr_done    (clr_done),
  .done        (done),
  .busy        (busy),
  .erase_end   (erase_end)
);

// File: tb/sim_vecdisp_done_timer.sv
`timescale 1ns/1ps
module sim_vecdisp_done_timer;

  localparam int KHZ = 3000;

  function automatic int cyc(input longint ns);
    longint c;
    c = (ns * KHZ + 999999) / 1000000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int LAS = 8, LAL = 27, LBS = 11, LBL = 33;
  localparam int LINT = 18, LSTA = 2, LSET = 60, LERA = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_ld_x = 0, cmd_ld_y = 0, cmd_intens = 0, cmd_ld_stat = 0;
  logic stat_colour = 0, len_long = 0, erase_ival = 0, clr_done = 0;
  logic done, erase_end;
  logic [3:0] busy;

  always #2.5 clk = ~clk;

  vecdisp_done_timer #(.CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst(rst), .cmd_ld_x(cmd_ld_x), .cmd_ld_y(cmd_ld_y),
    .cmd_intens(cmd_intens), .cmd_ld_stat(cmd_ld_stat), .stat_colour(stat_colour),
    .len_long(len_long), .erase_ival(erase_ival), .clr_done(clr_done),
    .done(done), .busy(busy), .erase_end(erase_end)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  bit cmp_on = 0;
  logic [3:0] first_busy;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle model built from the requirements
  int rem[4];
  int erem;
  bit col_m, idle_q_m, done_m, er_prev, idle_now, anyc, fall;
  int mlen;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) rem[k] = 0;
      erem = 0; col_m = 0; idle_q_m = 1; done_m = 0; er_prev = 0;
    end else begin
      idle_now = (rem[0] == 0) && (rem[1] == 0) && (rem[2] == 0) && (rem[3] == 0);
      anyc = cmd_ld_x | cmd_ld_y | cmd_intens | cmd_ld_stat;
      if (anyc || clr_done) done_m = 0;
      else if (idle_now && !idle_q_m) done_m = 1;
      idle_q_m = idle_now;
      mlen = col_m ? (len_long ? LBL : LBS) : (len_long ? LAL : LAS);
      if (cmd_ld_x || cmd_ld_y) rem[0] = mlen; else if (rem[0] > 0) rem[0]--;
      if (cmd_intens) rem[1] = LINT; else if (rem[1] > 0) rem[1]--;
      if (cmd_ld_stat) rem[2] = LSTA; else if (rem[2] > 0) rem[2]--;
      if (cmd_ld_stat && stat_colour != col_m) rem[3] = LSET; else if (rem[3] > 0) rem[3]--;
      if (cmd_ld_stat) col_m = stat_colour;
      fall = er_prev && !erase_ival;
      er_prev = erase_ival;
      if (fall) erem = LERA; else if (erem > 0) erem--;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2/R3 model done", done, done_m);
      chk("R4/R5/R6/R7/R8/R9 model busy", busy,
          {rem[3] > 0, rem[2] > 0, rem[1] > 0, rem[0] > 0});
      chk("R11 model erase_end", erase_end, erem > 0);
    end
  end

  // kind: 0 load X, 1 load Y, 2 intensify, 3 load status
  task automatic strobe(input int kind, input bit col);
    @(negedge clk);
    stat_colour = col;
    case (kind)
      0: cmd_ld_x = 1;
      1: cmd_ld_y = 1;
      2: cmd_intens = 1;
      default: cmd_ld_stat = 1;
    endcase
    @(negedge clk);
    cmd_ld_x = 0; cmd_ld_y = 0; cmd_intens = 0; cmd_ld_stat = 0;
  endtask

  task automatic run_timed(input int kind, input bit col, input int len,
                           input int idx, input string req);
    strobe(kind, col);
    first_busy = busy;
    chk({req, " busy start"}, busy[idx], 1);
    chk("R2 done cleared", done, 0);
    repeat (len - 1) @(negedge clk);
    chk({req, " busy last cycle"}, busy[idx], 1);
    @(negedge clk);
    chk({req, " busy ended"}, busy, 0);
    chk("R3 done not yet", done, 0);
    @(negedge clk);
    chk("R3 done set", done, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1 done reset", done, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 erase_end reset", erase_end, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 done after reset", done, 0);

    chk("R7 rounding check", cyc(2600), LAS);
    len_long = 0; run_timed(0, 0, cyc(2600), 0, "R4 short");
    len_long = 1; run_timed(1, 0, cyc(8800), 0, "R4 long");
    run_timed(2, 0, cyc(6000), 1, "R6");
    len_long = 0; run_timed(3, 0, cyc(500), 2, "R7");
    chk("R8 no settle on same colour", first_busy[3], 0);
    run_timed(3, 1, cyc(20000), 3, "R8");
    chk("R8 settle started with status", first_busy, 4'b1100);
    len_long = 0; run_timed(0, 0, cyc(3400), 0, "R5 short");
    len_long = 1; run_timed(1, 0, cyc(11000), 0, "R5 long");

    // R10 clear flag
    @(negedge clk); clr_done = 1;
    @(negedge clk); clr_done = 0;
    chk("R10 done cleared", done, 0);
    repeat (5) @(negedge clk);
    chk("R10 done stays low", done, 0);

    // R9 restart
    strobe(2, 1);
    repeat (9) @(negedge clk);
    run_timed(2, 1, LINT, 1, "R9 restart");

    // R11 erase end
    @(negedge clk); erase_ival = 1;
    @(negedge clk);
    chk("R11 no pulse on rise", erase_end, 0);
    repeat (3) @(negedge clk);
    erase_ival = 0;
    @(negedge clk);
    chk("R11 pulse start", erase_end, 1);
    chk("R11 busy untouched", busy, 0);
    repeat (LERA - 1) @(negedge clk);
    chk("R11 pulse last", erase_end, 1);
    @(negedge clk);
    chk("R11 pulse end", erase_end, 0);
    chk("R11 done untouched", done, 1);

    // random phase against the model
    cmp_on = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cmd_ld_x    = ($urandom % 40) == 0;
      cmd_ld_y    = ($urandom % 40) == 0;
      cmd_intens  = ($urandom % 50) == 0;
      cmd_ld_stat = ($urandom % 60) == 0;
      stat_colour = $urandom % 2;
      clr_done    = ($urandom % 80) == 0;
      if (($urandom % 30) == 0) erase_ival = ~erase_ival;
      if (($urandom % 100) == 0) len_long = ~len_long;
    end
    @(negedge clk);
    cmd_ld_x = 0; cmd_ld_y = 0; cmd_intens = 0; cmd_ld_stat = 0; clr_done = 0;
    repeat (80) @(negedge clk);
    cmp_on = 0;

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule